// File: doc/BRIEF.md
# Accumulator Execute Stage with Selectable Write-Back

This block performs the data work of a small 8-bit accumulator machine. It holds a working register W, a directly addressed register file of 2^ADDR_W bytes (128 by default), and the two status flags Z (zero) and C (carry). Each clock cycle in which `op_valid` is high, it takes one decoded operation and completes it in that cycle. It reads the addressed byte, combines it with W or with the literal, and writes the result into W or into the addressed byte. It then updates the flags that the operation is defined to touch.

An upstream decoder supplies the opcode, address, destination select, bit position and literal. A separate control unit uses the `res_zero` output, which is valid in the same cycle as the operation, to build increment-or-decrement-and-skip behaviour. The block does no fetching, no branching and no skipping itself.

Top module: `acc_exec`

## Requirements
- R1: Operations that take a register operand and a destination (MOVF, SWAPF, INCF, DECF, COMF, ADDWF, SUBWF, ANDWF, IORWF, XORWF, RLF, RRF) write the result to the addressed register when `op_dest`=1, leaving W unchanged. When `op_dest`=0 they write W, leaving the register unchanged. A rotate that targets W leaves its source register intact.
- R2: BSF (7) forces bit `op_bit` of the addressed register to 1, and BCF (8) forces it to 0. The other seven bits, W and both flags are unchanged.
- R3: ANDLW/IORLW/XORLW (16/18/20) combine the literal with W into W. ANDWF/IORWF/XORWF (17/19/21) combine W with the register. All six set Z from the 8-bit result and leave C unchanged.
- R4: RLF (22) produces {f[6:0], C} and loads f[7] into C. Z is unchanged.
- R5: RRF (23) produces {C, f[7:1]} and loads f[0] into C. Z is unchanged.
- R6: SUBWF (15) computes register minus W, and SUBLW (14) computes literal minus W. C is set to 1 when the first operand is greater than or equal to W, and Z is set to 1 when the two are equal.
- R7: ADDLW (12) computes literal plus W, and ADDWF (13) computes register plus W. C is the carry out of bit 7, and Z is set from the 8-bit sum.
- R8: CLRW (1) clears W and CLRF (2) clears the register; both set Z. MOVF (5) copies the register and sets Z from it. MOVLW (3) loads the literal into W, MOVWF (4) copies W into the register, and SWAPF (6) exchanges the two nibbles. These last three change no flag.
- R9: INCF (9), DECF (10) and COMF (11) add one to the register, subtract one from it, or invert it (8-bit wrap). They set Z from the result and leave C unchanged.
- R10: After reset, W, Z, C and every register byte read as zero.
- R11: `res_zero` is high in the cycle of a valid operation whose 8-bit result is zero, for every opcode 1 to 23. It is low otherwise. Z, when updated, takes that same value.
- R12: While `op_valid` is low, and for opcodes 0 and 24 to 31, W, the flags and the register file stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Opcode (values in the requirements) |
| op_addr | input | ADDR_W | Direct register address |
| op_dest | input | 1 | 1 = write register, 0 = write W |
| op_bit | input | 3 | Bit position for BSF/BCF |
| op_lit | input | 8 | Literal operand |
| w_q | output | 8 | Working register |
| z_q | output | 1 | Zero flag |
| c_q | output | 1 | Carry flag (no-borrow after subtract) |
| res_zero | output | 1 | Current operation's result is zero |

## Verification
Two functions can fall in the same cycle. The first is the rotate: the old carry is read into the result while the new carry is written from the operand. The second is a register write-back followed directly by an operation that reads the same byte. The bench issues operations back to back over a small window of addresses, with rotates and carry-producing adds and subtracts densely mixed. It judges every cycle's W, Z, C and `res_zero` against a bench model. A final sweep reads every touched byte back through MOVF to W.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DW  = 8;
  localparam int BW  = $clog2(DW);
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 5'd0,  OP_CLRW  = 5'd1,  OP_CLRF  = 5'd2,  OP_MOVLW = 5'd3,
    OP_MOVWF = 5'd4,  OP_MOVF  = 5'd5,  OP_SWAPF = 5'd6,  OP_BSF   = 5'd7,
    OP_BCF   = 5'd8,  OP_INCF  = 5'd9,  OP_DECF  = 5'd10, OP_COMF  = 5'd11,
    OP_ADDLW = 5'd12, OP_ADDWF = 5'd13, OP_SUBLW = 5'd14, OP_SUBWF = 5'd15,
    OP_ANDLW = 5'd16, OP_ANDWF = 5'd17, OP_IORLW = 5'd18, OP_IORWF = 5'd19,
    OP_XORLW = 5'd20, OP_XORWF = 5'd21, OP_RLF   = 5'd22, OP_RRF   = 5'd23
  } op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c_new;
    logic          upd_z;
    logic          upd_c;
    logic          to_w;
    logic          to_reg;
    logic          has_res;
  } alu_out_t;

  // {carry, sum}
  function automatic logic [DW:0] add_c(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // {no_borrow, a - b}
  function automatic logic [DW:0] sub_nb(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, 1'b1};
  endfunction

  // {carry_out, rotated}
  function automatic logic [DW:0] rot_l(input logic [DW-1:0] v, input logic cin);
    return {v, cin};
  endfunction

  function automatic logic [DW:0] rot_r(input logic [DW-1:0] v, input logic cin);
    return {v[0], cin, v[DW-1:1]};
  endfunction

  function automatic logic [DW-1:0] swap_nib(input logic [DW-1:0] v);
    return {v[DW/2-1:0], v[DW-1:DW/2]};
  endfunction

  function automatic logic [DW-1:0] bit_mask(input logic [BW-1:0] pos);
    logic [DW-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  w_val,
  input  logic [DW-1:0]  f_val,
  input  logic           dest,
  input  logic [BW-1:0]  bitpos,
  input  logic [DW-1:0]  lit,
  input  logic           c_in,
  output alu_out_t       ao
);
  logic [DW:0] t;

  always_comb begin
    ao       = '0;
    ao.c_new = c_in;
    t        = '0;
    case (op_code)
      OP_CLRW:  begin ao.res = '0; ao.upd_z = 1'b1; ao.to_w = 1'b1; end
      OP_CLRF:  begin ao.res = '0; ao.upd_z = 1'b1; ao.to_reg = 1'b1; end
      OP_MOVLW: begin ao.res = lit; ao.to_w = 1'b1; end
      OP_MOVWF: begin ao.res = w_val; ao.to_reg = 1'b1; end
      OP_MOVF:  begin ao.res = f_val; ao.upd_z = 1'b1; end
      OP_SWAPF: ao.res = swap_nib(f_val);
      OP_BSF:   begin ao.res = f_val | bit_mask(bitpos); ao.to_reg = 1'b1; end
      OP_BCF:   begin ao.res = f_val & ~bit_mask(bitpos); ao.to_reg = 1'b1; end
      OP_INCF:  begin ao.res = f_val + 1'b1; ao.upd_z = 1'b1; end
      OP_DECF:  begin ao.res = f_val - 1'b1; ao.upd_z = 1'b1; end
      OP_COMF:  begin ao.res = ~f_val; ao.upd_z = 1'b1; end
      OP_ADDLW: begin t = add_c(lit, w_val); ao.to_w = 1'b1; end
      OP_ADDWF: t = add_c(f_val, w_val);
      OP_SUBLW: begin t = sub_nb(lit, w_val); ao.to_w = 1'b1; end
      OP_SUBWF: t = sub_nb(f_val, w_val);
      OP_ANDLW: begin ao.res = lit & w_val; ao.upd_z = 1'b1; ao.to_w = 1'b1; end
      OP_ANDWF: begin ao.res = f_val & w_val; ao.upd_z = 1'b1; end
      OP_IORLW: begin ao.res = lit | w_val; ao.upd_z = 1'b1; ao.to_w = 1'b1; end
      OP_IORWF: begin ao.res = f_val | w_val; ao.upd_z = 1'b1; end
      OP_XORLW: begin ao.res = lit ^ w_val; ao.upd_z = 1'b1; ao.to_w = 1'b1; end
      OP_XORWF: begin ao.res = f_val ^ w_val; ao.upd_z = 1'b1; end
      OP_RLF:   t = rot_l(f_val, c_in);
      OP_RRF:   t = rot_r(f_val, c_in);
      default:  ;
    endcase

    // arithmetic and rotate results come through t
    case (op_code)
      OP_ADDLW, OP_ADDWF, OP_SUBLW, OP_SUBWF: begin
        ao.res = t[DW-1:0]; ao.c_new = t[DW]; ao.upd_c = 1'b1; ao.upd_z = 1'b1;
      end
      OP_RLF, OP_RRF: begin
        ao.res = t[DW-1:0]; ao.c_new = t[DW]; ao.upd_c = 1'b1;
      end
      default: ;
    endcase

    // register-operand ops with a selectable destination
    case (op_code)
      OP_MOVF, OP_SWAPF, OP_INCF, OP_DECF, OP_COMF, OP_ADDWF, OP_SUBWF,
      OP_ANDWF, OP_IORWF, OP_XORWF, OP_RLF, OP_RRF: begin
        ao.to_reg = dest;
        ao.to_w   = !dest;
      end
      default: ;
    endcase

    ao.has_res = (op_code != OP_NOP) && (op_code <= OP_RRF);
  end
endmodule

// File: rtl/acc_exec.sv
module acc_exec
  import acc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPW-1:0]    op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_dest,
  input  logic [BW-1:0]     op_bit,
  input  logic [DW-1:0]     op_lit,
  output logic [DW-1:0]     w_q,
  output logic              z_q,
  output logic              c_q,
  output logic              res_zero
);
  logic [DW-1:0] rd_data;
  alu_out_t      ao;

  // named events for the checker
  logic wr_reg_ev, wr_w_ev, z_upd, c_upd;

  acc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (op_addr),
    .rd_data (rd_data),
    .we      (wr_reg_ev),
    .wr_addr (op_addr),
    .wr_data (ao.res)
  );

  acc_alu u_alu (
    .op_code (op_code),
    .w_val   (w_q),
    .f_val   (rd_data),
    .dest    (op_dest),
    .bitpos  (op_bit),
    .lit     (op_lit),
    .c_in    (c_q),
    .ao      (ao)
  );

  assign wr_reg_ev = op_valid && ao.to_reg;
  assign wr_w_ev   = op_valid && ao.to_w;
  assign z_upd     = op_valid && ao.upd_z;
  assign c_upd     = op_valid && ao.upd_c;
  assign res_zero  = op_valid && ao.has_res && (ao.res == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      if (wr_w_ev) w_q <= ao.res;
      if (z_upd)   z_q <= res_zero;
      if (c_upd)   c_q <= ao.c_new;
    end
  end
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk
  import acc_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [OPW-1:0] op_code,
  input logic [DW-1:0]  rd_data,
  input logic [DW-1:0]  w_q,
  input logic           z_q,
  input logic           c_q,
  input logic           res_zero,
  input logic           wr_reg_ev,
  input logic           wr_w_ev,
  input logic           z_upd,
  input logic           c_upd
);
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_reg_ev && wr_w_ev)); // R1
  AST_W_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_w_ev |=> w_q == $past(w_q)); // R1
  AST_Z_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !z_upd |=> z_q == $past(z_q)); // R3
  AST_C_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !c_upd |=> c_q == $past(c_q)); // R9
  AST_RLF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RLF) |=> c_q == $past(rd_data[DW-1])); // R4
  AST_RRF_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RRF) |=> c_q == $past(rd_data[0])); // R5
  AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SUBWF) |=> c_q == ($past(rd_data) >= $past(w_q))); // R6
  AST_Z_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    z_upd |=> z_q == $past(res_zero)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !(wr_reg_ev || wr_w_ev || z_upd || c_upd || res_zero)); // R12
endmodule

bind acc_exec acc_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .rd_data   (rd_data),
  .w_q       (w_q),
  .z_q       (z_q),
  .c_q       (c_q),
  .res_zero  (res_zero),
  .wr_reg_ev (wr_reg_ev),
  .wr_w_ev   (wr_w_ev),
  .z_upd     (z_upd),
  .c_upd     (c_upd)
);

// File: tb/sim_acc_exec.sv
`timescale 1ns/1ps
module sim_acc_exec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [6:0] op_addr = '0;
  logic       op_dest = 1'b0;
  logic [2:0] op_bit = '0;
  logic [7:0] op_lit = '0;
  logic [7:0] w_q;
  logic       z_q, c_q, res_zero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_mem [128];
  logic [7:0] m_w;
  logic       m_z, m_c;

  always #10 clk = ~clk;

  acc_exec u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_dest(op_dest), .op_bit(op_bit), .op_lit(op_lit),
    .w_q(w_q), .z_q(z_q), .c_q(c_q), .res_zero(res_zero)
  );

  function automatic string req_of(input int op);
    case (op)
      7, 8:                   return "R2";
      16, 17, 18, 19, 20, 21: return "R3";
      22:                     return "R4";
      23:                     return "R5";
      14, 15:                 return "R6";
      12, 13:                 return "R7";
      1, 2, 3, 4, 5, 6:       return "R8";
      9, 10, 11:              return "R9";
      default:                return "R12";
    endcase
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // one operation, driven at a falling edge, judged at the next one
  task automatic run_op(input bit vld, input int op, input int addr, input bit dst,
                        input int bp, input int lit);
    int f, r, nz, nc, sum;
    bit upd_z, upd_c, to_w, to_reg, has;
    string rq;
    op_valid = vld; op_code = 5'(op); op_addr = 7'(addr);
    op_dest = dst; op_bit = 3'(bp); op_lit = 8'(lit);
    rq = vld ? req_of(op) : "R12";
    f = int'(m_mem[addr]);
    r = 0; nc = int'(m_c); upd_z = 0; upd_c = 0; to_w = 0; to_reg = 0;
    has = vld && op >= 1 && op <= 23;
    case (op)
      1:  begin r = 0; upd_z = 1; to_w = 1; end
      2:  begin r = 0; upd_z = 1; to_reg = 1; end
      3:  begin r = lit; to_w = 1; end
      4:  begin r = int'(m_w); to_reg = 1; end
      5:  begin r = f; upd_z = 1; end
      6:  r = (f % 16) * 16 + f / 16;
      7:  begin r = f | (1 << bp); to_reg = 1; end
      8:  begin r = f & (255 - (1 << bp)); to_reg = 1; end
      9:  begin r = (f + 1) % 256; upd_z = 1; end
      10: begin r = (f + 255) % 256; upd_z = 1; end
      11: begin r = 255 - f; upd_z = 1; end
      12, 13: begin
        sum = (op == 12 ? lit : f) + int'(m_w);
        r = sum % 256; nc = sum > 255 ? 1 : 0; upd_z = 1; upd_c = 1; to_w = (op == 12);
      end
      14, 15: begin
        sum = (op == 14 ? lit : f);
        r = (sum - int'(m_w) + 256) % 256; nc = sum >= int'(m_w) ? 1 : 0;
        upd_z = 1; upd_c = 1; to_w = (op == 14);
      end
      16, 17: begin r = (op == 16 ? lit : f) & int'(m_w); upd_z = 1; to_w = (op == 16); end
      18, 19: begin r = (op == 18 ? lit : f) | int'(m_w); upd_z = 1; to_w = (op == 18); end
      20, 21: begin r = (op == 20 ? lit : f) ^ int'(m_w); upd_z = 1; to_w = (op == 20); end
      22: begin r = (f * 2) % 256 + int'(m_c); nc = f / 128; upd_c = 1; end
      23: begin r = f / 2 + 128 * int'(m_c); nc = f % 2; upd_c = 1; end
      default: ;
    endcase
    if (op inside {5, 6, 9, 10, 11, 13, 15, 17, 19, 21, 22, 23}) begin
      to_reg = dst; to_w = !dst;
    end
    nz = (r == 0) ? 1 : 0;
    #1;
    check("R11", "res_zero", int'(res_zero), (has && nz == 1) ? 1 : 0);
    if (vld) begin
      if (to_w) m_w = 8'(r);
      if (to_reg) m_mem[addr] = 8'(r);
      if (upd_z) m_z = nz[0];
      if (upd_c) m_c = nc[0];
    end
    @(posedge clk);
    @(negedge clk);
    check(rq, "W", int'(w_q), int'(m_w));
    check(rq, "Z", int'(z_q), int'(m_z));
    check(rq, "C", int'(c_q), int'(m_c));
    if (dst == 0 && op inside {22, 23})
      check("R1", "rotate-to-W source kept", int'(m_mem[addr]), f);
  endtask

  // read a byte through MOVF to W and compare
  task automatic peek(input int addr, input string rq);
    logic [7:0] expv;
    expv = m_mem[addr];
    run_op(1, 5, addr, 0, 0, 0);
    check(rq, "readback", int'(w_q), int'(expv));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    m_w = '0; m_z = 0; m_c = 0;
    void'($urandom(32'd20131));
    #35 rst_n = 1'b1;
    @(negedge clk);
    check("R10", "W after reset", int'(w_q), 0);
    check("R10", "Z after reset", int'(z_q), 0);
    check("R10", "C after reset", int'(c_q), 0);
    peek(100, "R10");

    // directed: logic, rotate and mask chain at address 0x40
    run_op(1, 2, 64, 1, 0, 0);      // CLRF, R8
    run_op(1, 3, 0, 0, 0, 8'hF0);   // MOVLW
    run_op(1, 19, 64, 1, 0, 0);     // IORWF to reg, R3
    run_op(1, 20, 0, 0, 0, 8'hFF);  // XORLW, R3
    run_op(1, 23, 64, 1, 0, 0);     // RRF to reg, R5
    check("R5", "rrf result", int'(m_mem[64]), 8'h78);
    run_op(1, 17, 64, 0, 0, 0);     // ANDWF to W, R3
    check("R3", "andwf to W", int'(w_q), 8'h08);
    run_op(1, 22, 64, 1, 0, 0);     // RLF to reg, R4
    peek(64, "R4");

    // subtract corners, R6
    run_op(1, 3, 0, 0, 0, 8'h55);
    run_op(1, 4, 10, 1, 0, 0);      // reg = 0x55
    run_op(1, 15, 10, 0, 0, 0);     // equal: Z=1 C=1
    check("R6", "equal sets Z", int'(z_q), 1);
    run_op(1, 3, 0, 0, 0, 8'h56);
    run_op(1, 15, 10, 0, 0, 0);     // smaller: C=0
    check("R6", "borrow clears C", int'(c_q), 0);
    run_op(1, 14, 0, 0, 0, 8'h00);  // 0 - W
    // add overflow, R7
    run_op(1, 3, 0, 0, 0, 8'hFF);
    run_op(1, 12, 0, 0, 0, 8'h01);
    check("R7", "add carry", int'(c_q), 1);
    // inc wrap, R9 / R11
    run_op(1, 3, 0, 0, 0, 8'hFF);
    run_op(1, 4, 11, 1, 0, 0);
    run_op(1, 9, 11, 0, 0, 0);      // W = 0, reg unchanged, R1
    peek(11, "R1");
    // bit ops across every position, R2
    for (int b = 0; b < 8; b++) run_op(1, 7, 12, 1, b, 0);
    peek(12, "R2");
    for (int b = 0; b < 8; b += 2) run_op(1, 8, 12, 1, b, 0);
    peek(12, "R2");
    // idle and unused opcodes, R12
    run_op(0, 2, 12, 1, 0, 0);
    run_op(1, 27, 12, 1, 0, 0);
    run_op(1, 0, 12, 1, 0, 0);
    peek(12, "R12");

    // random mix over a small address window
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 25));
      run_op(($urandom_range(0, 15) != 0), op, int'($urandom_range(0, 7)),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
             int'($urandom_range(0, 255)));
    end
    for (int a = 0; a < 8; a++) peek(a, "R1");

    op_valid = 1'b0;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule